// File: doc/BRIEF.md
# Word-Strided Peripheral Register Window

This block is the register window for a small cluster of I/O peripherals: a serial link, an input (controller) port, a 16-bit timer and the memory wait-state control. A bus master presents an 8-bit offset inside the I/O region, an access size and, for writes, a data value. The block works out which of eleven byte-wide registers is hit, checks whether the access width fits that register's alignment, and either returns zero-extended read data or turns the write into a one-cycle strobe for the owning unit.

The registers sit four bytes apart. Offset bits 5:2 pick the register, and offset bits above bit 5 are ignored, so the window repeats through the region. The timer, link and input units live outside this block. Their readable state comes in on input ports, and their writable registers are served by write strobes plus a shared write byte. Only two items are stored here: the link transmit byte and the two wait-state bits.

Every access is answered one clock after it is presented. A read raises `rd_valid` with `rd_data`. An accepted write to an external register raises exactly one strobe alongside `wr_byte`.

Top module: `pio_regwin`

## Requirements
- R1: A permitted read returns the addressed register zero-extended to 32 bits. Index 0 is link control, 1 link status, 2 link transmit, 3 link receive, 4 input low byte, 5 input high byte, 6 timer low, 7 timer high, 8 timer control, 9 wait control and 10 input control.
- R2: Index 6 reads bits 7:0 of `tmr_count` and index 7 reads bits 15:8.
- R3: A byte access (`acc_size`=00) with either of offset bits 1:0 set reads 0 and writes nothing.
- R4: A halfword access (`acc_size`=01) with offset bit 1 set reads 0 and writes nothing. A word access (`acc_size`=10 or 11) is never refused for its alignment.
- R5: Indices 11 to 15 read 0, and writes to them change no state and raise no strobe.
- R6: Writes to indices 3, 4 and 5 raise no strobe and leave the read-back values unchanged.
- R7: A permitted write to index 2 stores `acc_wdata[7:0]`, and later reads of index 2 return it.
- R8: A permitted write to index 9 sets `wait_rom` from data bit 0 and `wait_exp` from data bit 1. A read of index 9 returns {exp, rom} in bits 1:0.
- R9: A permitted write to index 0, 1, 6, 7, 8 or 10 raises the matching strobe for one cycle (`wr_lnk_ctl`, `wr_lnk_sts`, `wr_tmr_lo`, `wr_tmr_hi`, `wr_tmr_ctl` or `wr_pad_ctl`), with `wr_byte` equal to `acc_wdata[7:0]`. At most one strobe is high in any cycle.
- R10: Offset bits 7:6 have no effect on decoding.
- R11: While reset is asserted and after it, `lnk_tx`, `wait_rom`, `wait_exp`, `rd_valid`, `rd_data` and all strobes are 0.
- R12: An access presented with `acc_valid` high at a clock edge is answered after that edge: `rd_valid` for a read, a strobe or a stored update for a write. `rd_valid` is never high together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_off | input | 8 | Byte offset within the I/O region |
| acc_wdata | input | 32 | Write data; only bits 7:0 are used |
| lnk_ctl_in | input | 8 | Link control read value |
| lnk_sts_in | input | 8 | Link status read value |
| lnk_rx_in | input | 8 | Link receive byte |
| pad_lo_in | input | 8 | Input port low byte |
| pad_hi_in | input | 8 | Input port high byte |
| tmr_count | input | 16 | Timer counter |
| tmr_ctl_in | input | 8 | Timer control read value |
| pad_ctl_in | input | 8 | Input port control read value |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| wr_lnk_ctl | output | 1 | Write strobe, link control |
| wr_lnk_sts | output | 1 | Write strobe, link status |
| wr_tmr_lo | output | 1 | Write strobe, timer reload low |
| wr_tmr_hi | output | 1 | Write strobe, timer reload high |
| wr_tmr_ctl | output | 1 | Write strobe, timer control |
| wr_pad_ctl | output | 1 | Write strobe, input port control |
| wr_byte | output | 8 | Byte that goes with the write strobe |
| lnk_tx | output | 8 | Stored link transmit byte |
| wait_rom | output | 1 | ROM wait-state select |
| wait_exp | output | 1 | Expansion wait-state select |

## Verification
The hardest cases to reach are the narrow accesses that land inside a register's word without hitting its base. They must be refused silently, with no strobe and no change to stored state, yet a refused read must still return a zero response. The stimulus therefore aims byte and halfword writes at the unaligned bytes of the transmit and wait registers and at the strobed registers, then reads those registers back at an aligned offset to show nothing moved. Aliased offsets with bits 7:6 set, and back-to-back reads and writes, cover decoding and response timing.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  localparam int IDX_W    = 4;
  localparam int NUM_REGS = 11;

  localparam logic [IDX_W-1:0] IX_LNK_CTL = 4'd0;
  localparam logic [IDX_W-1:0] IX_LNK_STS = 4'd1;
  localparam logic [IDX_W-1:0] IX_LNK_TX  = 4'd2;
  localparam logic [IDX_W-1:0] IX_LNK_RX  = 4'd3;
  localparam logic [IDX_W-1:0] IX_PAD_LO  = 4'd4;
  localparam logic [IDX_W-1:0] IX_PAD_HI  = 4'd5;
  localparam logic [IDX_W-1:0] IX_TMR_LO  = 4'd6;
  localparam logic [IDX_W-1:0] IX_TMR_HI  = 4'd7;
  localparam logic [IDX_W-1:0] IX_TMR_CTL = 4'd8;
  localparam logic [IDX_W-1:0] IX_WAIT    = 4'd9;
  localparam logic [IDX_W-1:0] IX_PAD_CTL = 4'd10;

  typedef struct packed {
    logic pad_ctl;
    logic tmr_ctl;
    logic tmr_hi;
    logic tmr_lo;
    logic lnk_sts;
    logic lnk_ctl;
  } wr_strb_t;

endpackage

// File: rtl/pio_gate.sv
module pio_gate
  import pio_pkg::*;
#(
  parameter int OFF_W       = 8,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] off,
  output logic             permit,
  output logic             mapped,
  output logic [IDX_W-1:0] idx
);

  localparam int IDX_LSB = STRIDE_LOG2;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic unused_hi;
  assign unused_hi = ^off[OFF_W-1:IDX_MSB+1];

  assign idx    = off[IDX_MSB:IDX_LSB];
  assign mapped = (idx < IDX_W'(NUM_REGS));

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: permit = (off[STRIDE_LOG2-1:0] == '0);
      SZ_HALF: permit = (off[STRIDE_LOG2-1:1] == '0);
      default: permit = 1'b1;
    endcase
  end

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
  import pio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 8
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic               permit,
  input  logic [REG_W-1:0]   lnk_ctl_in,
  input  logic [REG_W-1:0]   lnk_sts_in,
  input  logic [REG_W-1:0]   lnk_tx_q,
  input  logic [REG_W-1:0]   lnk_rx_in,
  input  logic [REG_W-1:0]   pad_lo_in,
  input  logic [REG_W-1:0]   pad_hi_in,
  input  logic [2*REG_W-1:0] tmr_count,
  input  logic [REG_W-1:0]   tmr_ctl_in,
  input  logic               wait_rom_q,
  input  logic               wait_exp_q,
  input  logic [REG_W-1:0]   pad_ctl_in,
  output logic [DATA_W-1:0]  rd_word
);

  localparam int PAD_W = DATA_W - REG_W;

  logic [REG_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    unique case (idx)
      IX_LNK_CTL: sel_byte = lnk_ctl_in;
      IX_LNK_STS: sel_byte = lnk_sts_in;
      IX_LNK_TX:  sel_byte = lnk_tx_q;
      IX_LNK_RX:  sel_byte = lnk_rx_in;
      IX_PAD_LO:  sel_byte = pad_lo_in;
      IX_PAD_HI:  sel_byte = pad_hi_in;
      IX_TMR_LO:  sel_byte = tmr_count[REG_W-1:0];
      IX_TMR_HI:  sel_byte = tmr_count[2*REG_W-1:REG_W];
      IX_TMR_CTL: sel_byte = tmr_ctl_in;
      IX_WAIT:    sel_byte = {{(REG_W-2){1'b0}}, wait_exp_q, wait_rom_q};
      IX_PAD_CTL: sel_byte = pad_ctl_in;
      default:    sel_byte = '0;
    endcase
  end

  assign rd_word = permit ? {{PAD_W{1'b0}}, sel_byte} : '0;

endmodule

// File: rtl/pio_wrdec.sv
module pio_wrdec
  import pio_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wbyte,
  output wr_strb_t         strb_q,
  output logic [REG_W-1:0] tx_q,
  output logic             wait_rom_q,
  output logic             wait_exp_q
);

  wr_strb_t         strb_d;
  logic [REG_W-1:0] tx_d;
  logic             wait_rom_d;
  logic             wait_exp_d;
  logic             tx_en;
  logic             wait_en;

  assign tx_en   = wr_en && (idx == IX_LNK_TX);
  assign wait_en = wr_en && (idx == IX_WAIT);

  always_comb begin
    strb_d         = '0;
    strb_d.lnk_ctl = wr_en && (idx == IX_LNK_CTL);
    strb_d.lnk_sts = wr_en && (idx == IX_LNK_STS);
    strb_d.tmr_lo  = wr_en && (idx == IX_TMR_LO);
    strb_d.tmr_hi  = wr_en && (idx == IX_TMR_HI);
    strb_d.tmr_ctl = wr_en && (idx == IX_TMR_CTL);
    strb_d.pad_ctl = wr_en && (idx == IX_PAD_CTL);
  end

  always_comb begin
    tx_d       = tx_en   ? wbyte    : tx_q;
    wait_rom_d = wait_en ? wbyte[0] : wait_rom_q;
    wait_exp_d = wait_en ? wbyte[1] : wait_exp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q     <= '0;
      tx_q       <= '0;
      wait_rom_q <= 1'b0;
      wait_exp_q <= 1'b0;
    end else begin
      strb_q     <= strb_d;
      tx_q       <= tx_d;
      wait_rom_q <= wait_rom_d;
      wait_exp_q <= wait_exp_d;
    end
  end

endmodule

// File: rtl/pio_regwin.sv
module pio_regwin
  import pio_pkg::*;
#(
  parameter int OFF_W       = 8,
  parameter int DATA_W      = 32,
  parameter int REG_W       = 8,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_we,
  input  logic [1:0]          acc_size,
  input  logic [OFF_W-1:0]    acc_off,
  input  logic [DATA_W-1:0]   acc_wdata,
  input  logic [REG_W-1:0]    lnk_ctl_in,
  input  logic [REG_W-1:0]    lnk_sts_in,
  input  logic [REG_W-1:0]    lnk_rx_in,
  input  logic [REG_W-1:0]    pad_lo_in,
  input  logic [REG_W-1:0]    pad_hi_in,
  input  logic [2*REG_W-1:0]  tmr_count,
  input  logic [REG_W-1:0]    tmr_ctl_in,
  input  logic [REG_W-1:0]    pad_ctl_in,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                wr_lnk_ctl,
  output logic                wr_lnk_sts,
  output logic                wr_tmr_lo,
  output logic                wr_tmr_hi,
  output logic                wr_tmr_ctl,
  output logic                wr_pad_ctl,
  output logic [REG_W-1:0]    wr_byte,
  output logic [REG_W-1:0]    lnk_tx,
  output logic                wait_rom,
  output logic                wait_exp
);

  localparam int SYNC_DEPTH = 2;

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_DEPTH-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_DEPTH-1];

  logic unused_wd;
  assign unused_wd = ^acc_wdata[DATA_W-1:REG_W];

  logic             permit;
  logic             mapped;
  logic [IDX_W-1:0] idx;

  pio_gate #(
    .OFF_W       (OFF_W),
    .STRIDE_LOG2 (STRIDE_LOG2)
  ) u_gate (
    .size   (acc_size),
    .off    (acc_off),
    .permit (permit),
    .mapped (mapped),
    .idx    (idx)
  );

  logic [REG_W-1:0] tx_q;
  logic             wait_rom_q;
  logic             wait_exp_q;
  wr_strb_t         strb_q;
  logic             wr_en;

  assign wr_en = acc_valid && acc_we && permit && mapped;

  pio_wrdec #(
    .REG_W (REG_W)
  ) u_wrdec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .idx        (idx),
    .wbyte      (acc_wdata[REG_W-1:0]),
    .strb_q     (strb_q),
    .tx_q       (tx_q),
    .wait_rom_q (wait_rom_q),
    .wait_exp_q (wait_exp_q)
  );

  logic [DATA_W-1:0] rd_word;

  pio_rdmux #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
  ) u_rdmux (
    .idx        (idx),
    .permit     (permit),
    .lnk_ctl_in (lnk_ctl_in),
    .lnk_sts_in (lnk_sts_in),
    .lnk_tx_q   (tx_q),
    .lnk_rx_in  (lnk_rx_in),
    .pad_lo_in  (pad_lo_in),
    .pad_hi_in  (pad_hi_in),
    .tmr_count  (tmr_count),
    .tmr_ctl_in (tmr_ctl_in),
    .wait_rom_q (wait_rom_q),
    .wait_exp_q (wait_exp_q),
    .pad_ctl_in (pad_ctl_in),
    .rd_word    (rd_word)
  );

  // response registers
  logic              rd_en;
  logic              rd_valid_d;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_d;
  logic [DATA_W-1:0] rd_data_q;
  logic [REG_W-1:0]  wr_byte_d;
  logic [REG_W-1:0]  wr_byte_q;

  assign rd_en = acc_valid && !acc_we;

  always_comb begin
    rd_valid_d = rd_en;
    rd_data_d  = rd_en ? rd_word : rd_data_q;
    wr_byte_d  = wr_en ? acc_wdata[REG_W-1:0] : wr_byte_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      wr_byte_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
      wr_byte_q  <= wr_byte_d;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign wr_byte    = wr_byte_q;
  assign wr_lnk_ctl = strb_q.lnk_ctl;
  assign wr_lnk_sts = strb_q.lnk_sts;
  assign wr_tmr_lo  = strb_q.tmr_lo;
  assign wr_tmr_hi  = strb_q.tmr_hi;
  assign wr_tmr_ctl = strb_q.tmr_ctl;
  assign wr_pad_ctl = strb_q.pad_ctl;
  assign lnk_tx     = tx_q;
  assign wait_rom   = wait_rom_q;
  assign wait_exp   = wait_exp_q;

endmodule

// File: rtl/pio_regwin_chk.sv
module pio_regwin_chk #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_we,
  input logic [1:0]        acc_size,
  input logic [OFF_W-1:0]  acc_off,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [5:0]        strobes,
  input logic [REG_W-1:0]  lnk_tx,
  input logic              wait_rom,
  input logic              wait_exp
);

  logic byte_miss;
  logic half_miss;
  logic allowed;
  assign byte_miss = (acc_size == 2'b00) && (acc_off[1:0] != 2'b00);
  assign half_miss = (acc_size == 2'b01) && acc_off[1];
  assign allowed   = !byte_miss && !half_miss;

  // R3
  byte_rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we && byte_miss) |=> (rd_valid && rd_data == '0));

  // R3
  byte_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && byte_miss) |=>
      (strobes == '0 && $stable(lnk_tx) && $stable(wait_rom) && $stable(wait_exp)));

  // R4
  half_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && half_miss) |=>
      (strobes == '0 && $stable(lnk_tx) && $stable(wait_rom) && $stable(wait_exp)));

  // R5
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we && acc_off[5:2] > 4'd10) |=> (rd_data == '0));

  // R8
  wait_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && allowed && acc_off[5:2] == 4'd9) |=>
      ({wait_exp, wait_rom} == $past(acc_wdata[1:0])));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  // R12
  rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we) |=> rd_valid);

  // R12
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (strobes == '0));

endmodule

bind pio_regwin pio_regwin_chk #(
  .OFF_W  (OFF_W),
  .DATA_W (DATA_W),
  .REG_W  (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_valid (acc_valid),
  .acc_we    (acc_we),
  .acc_size  (acc_size),
  .acc_off   (acc_off),
  .acc_wdata (acc_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .strobes   ({wr_pad_ctl, wr_tmr_ctl, wr_tmr_hi, wr_tmr_lo, wr_lnk_sts, wr_lnk_ctl}),
  .lnk_tx    (lnk_tx),
  .wait_rom  (wait_rom),
  .wait_exp  (wait_exp)
);

// File: tb/pio_regwin_tb.sv
module pio_regwin_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_we = 1'b0;
  logic [1:0]  acc_size = 2'b10;
  logic [7:0]  acc_off = '0;
  logic [31:0] acc_wdata = '0;
  logic [7:0]  lnk_ctl_in = 8'hA1;
  logic [7:0]  lnk_sts_in = 8'hB2;
  logic [7:0]  lnk_rx_in  = 8'hC3;
  logic [7:0]  pad_lo_in  = 8'hD4;
  logic [7:0]  pad_hi_in  = 8'hE5;
  logic [15:0] tmr_count  = 16'h5A3C;
  logic [7:0]  tmr_ctl_in = 8'h96;
  logic [7:0]  pad_ctl_in = 8'h7E;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        wr_lnk_ctl, wr_lnk_sts, wr_tmr_lo, wr_tmr_hi, wr_tmr_ctl, wr_pad_ctl;
  logic [7:0]  wr_byte;
  logic [7:0]  lnk_tx;
  logic        wait_rom, wait_exp;

  always #10 clk = ~clk;

  pio_regwin u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_size(acc_size), .acc_off(acc_off), .acc_wdata(acc_wdata),
    .lnk_ctl_in(lnk_ctl_in), .lnk_sts_in(lnk_sts_in), .lnk_rx_in(lnk_rx_in),
    .pad_lo_in(pad_lo_in), .pad_hi_in(pad_hi_in), .tmr_count(tmr_count),
    .tmr_ctl_in(tmr_ctl_in), .pad_ctl_in(pad_ctl_in),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_lnk_ctl(wr_lnk_ctl), .wr_lnk_sts(wr_lnk_sts), .wr_tmr_lo(wr_tmr_lo),
    .wr_tmr_hi(wr_tmr_hi), .wr_tmr_ctl(wr_tmr_ctl), .wr_pad_ctl(wr_pad_ctl),
    .wr_byte(wr_byte), .lnk_tx(lnk_tx), .wait_rom(wait_rom), .wait_exp(wait_exp)
  );

  typedef struct {
    logic        rv;
    logic [31:0] rd;
    logic [5:0]  strb;
    logic [7:0]  wb;
    logic [7:0]  tx;
    logic [1:0]  wt;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  logic done = 1'b0;
  logic [7:0] m_tx = 8'h00;
  logic [1:0] m_wait = 2'b00;

  function automatic logic [7:0] model_rd(input logic [3:0] ix);
    case (ix)
      4'd0:  return lnk_ctl_in;
      4'd1:  return lnk_sts_in;
      4'd2:  return m_tx;
      4'd3:  return lnk_rx_in;
      4'd4:  return pad_lo_in;
      4'd5:  return pad_hi_in;
      4'd6:  return tmr_count[7:0];
      4'd7:  return tmr_count[15:8];
      4'd8:  return tmr_ctl_in;
      4'd9:  return {6'b0, m_wait};
      4'd10: return pad_ctl_in;
      default: return 8'h00;
    endcase
  endfunction

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] off,
                        input logic [31:0] wd, input string tag);
    exp_t e;
    logic ok;
    logic [3:0] ix;
    @(negedge clk);
    acc_valid = 1'b1; acc_we = we; acc_size = sz; acc_off = off; acc_wdata = wd;
    ix = off[5:2];
    ok = !((sz == 2'b00 && off[1:0] != 2'b00) || (sz == 2'b01 && off[1]));
    e.tag = tag; e.rv = !we; e.rd = '0; e.strb = '0; e.wb = wd[7:0];
    if (!we) e.rd = ok ? {24'b0, model_rd(ix)} : 32'b0;
    if (we && ok) begin
      case (ix)
        4'd0:  e.strb = 6'b000001;
        4'd1:  e.strb = 6'b000010;
        4'd6:  e.strb = 6'b000100;
        4'd7:  e.strb = 6'b001000;
        4'd8:  e.strb = 6'b010000;
        4'd10: e.strb = 6'b100000;
        4'd2:  m_tx = wd[7:0];
        4'd9:  m_wait = wd[1:0];
        default: ;
      endcase
    end
    e.tx = m_tx; e.wt = m_wait;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
    e.tag = "R12 idle"; e.rv = 1'b0; e.rd = '0; e.strb = '0; e.wb = '0;
    e.tx = m_tx; e.wt = m_wait;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expected item per clock after the capturing edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [5:0] s;
      logic mis;
      e = exp_q.pop_front();
      s = {wr_pad_ctl, wr_tmr_ctl, wr_tmr_hi, wr_tmr_lo, wr_lnk_sts, wr_lnk_ctl};
      mis = (rd_valid !== e.rv) || (e.rv && rd_data !== e.rd) || (s !== e.strb) ||
            (e.strb != 0 && wr_byte !== e.wb) || (lnk_tx !== e.tx) ||
            ({wait_exp, wait_rom} !== e.wt);
      total++;
      if (mis) begin
        bad++;
        $display("FAIL %s: got rv=%b rd=%h strb=%b wb=%h tx=%h wt=%b exp rv=%b rd=%h strb=%b wb=%h tx=%h wt=%b",
                 e.tag, rd_valid, rd_data, s, wr_byte, lnk_tx, {wait_exp, wait_rom},
                 e.rv, e.rd, e.strb, e.wb, e.tx, e.wt);
      end
    end
  end

  task automatic check_reset(input string tag);
    @(negedge clk);
    total++;
    if (rd_valid !== 1'b0 || rd_data !== '0 || lnk_tx !== 8'h00 || wait_rom !== 1'b0 ||
        wait_exp !== 1'b0 || {wr_pad_ctl, wr_tmr_ctl, wr_tmr_hi, wr_tmr_lo, wr_lnk_sts, wr_lnk_ctl} !== 6'b0) begin
      bad++;
      $display("FAIL %s: got rv=%b rd=%h tx=%h wt=%b exp all zero", tag,
               rd_valid, rd_data, lnk_tx, {wait_exp, wait_rom});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    check_reset("R11 in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check_reset("R11 after reset");

    // R1 R2 R5: every index, word reads
    for (int i = 0; i < 16; i++) access(1'b0, 2'b10, 8'(i * 4), 32'h0, $sformatf("R1/R5 read idx %0d", i));
    // R2: new counter value
    @(negedge clk) tmr_count = 16'hC7E1;
    access(1'b0, 2'b10, 8'h18, 0, "R2 timer low");
    access(1'b0, 2'b10, 8'h1C, 0, "R2 timer high");
    // R7
    access(1'b1, 2'b10, 8'h08, 32'hFFFF_FF5C, "R7 write tx");
    access(1'b0, 2'b10, 8'h08, 0, "R7 read tx");
    // R3 byte gating
    access(1'b1, 2'b00, 8'h09, 32'h11, "R3 byte wr +1");
    access(1'b1, 2'b00, 8'h0A, 32'h22, "R3 byte wr +2");
    access(1'b1, 2'b00, 8'h1B, 32'h33, "R3 byte wr timer +3");
    access(1'b1, 2'b00, 8'h25, 32'h03, "R3 byte wr wait +1");
    access(1'b0, 2'b00, 8'h09, 0, "R3 byte rd +1");
    access(1'b0, 2'b00, 8'h03, 0, "R3 byte rd ctl +3");
    access(1'b0, 2'b00, 8'h08, 0, "R3 byte rd aligned");
    access(1'b1, 2'b00, 8'h08, 32'h44, "R3 byte wr aligned");
    // R4 half gating, word never gated
    access(1'b1, 2'b01, 8'h0A, 32'h55, "R4 half wr +2");
    access(1'b1, 2'b01, 8'h22, 32'h55, "R4 half wr tctl +2");
    access(1'b0, 2'b01, 8'h0A, 0, "R4 half rd +2");
    access(1'b0, 2'b01, 8'h08, 0, "R4 half rd aligned");
    access(1'b1, 2'b01, 8'h09, 32'h66, "R4 half wr +1 allowed");
    access(1'b1, 2'b10, 8'h0B, 32'h77, "R4 word wr +3");
    access(1'b0, 2'b11, 8'h0A, 0, "R4 word rd +2");
    // R8 wait control
    access(1'b1, 2'b10, 8'h24, 32'h2, "R8 wait exp");
    access(1'b0, 2'b10, 8'h24, 0, "R8 read exp");
    access(1'b1, 2'b10, 8'h24, 32'hFD, "R8 wait rom");
    access(1'b0, 2'b10, 8'h24, 0, "R8 read rom");
    access(1'b1, 2'b00, 8'h24, 32'h3, "R8 byte wr both");
    access(1'b0, 2'b00, 8'h24, 0, "R8 read both");
    // R9 strobes
    access(1'b1, 2'b10, 8'h00, 32'h81, "R9 link ctl");
    access(1'b1, 2'b10, 8'h04, 32'h82, "R9 link sts");
    access(1'b1, 2'b00, 8'h18, 32'h83, "R9 timer lo");
    access(1'b1, 2'b01, 8'h1C, 32'h84, "R9 timer hi");
    access(1'b1, 2'b10, 8'h20, 32'h85, "R9 timer ctl");
    access(1'b1, 2'b10, 8'h28, 32'h86, "R9 pad ctl");
    // R6 read-only
    access(1'b1, 2'b10, 8'h0C, 32'h99, "R6 write rx");
    access(1'b1, 2'b10, 8'h10, 32'h99, "R6 write pad lo");
    access(1'b1, 2'b10, 8'h14, 32'h99, "R6 write pad hi");
    access(1'b0, 2'b10, 8'h0C, 0, "R6 read rx");
    access(1'b0, 2'b10, 8'h10, 0, "R6 read pad lo");
    access(1'b0, 2'b10, 8'h14, 0, "R6 read pad hi");
    // R5 unmapped writes
    for (int i = 11; i < 16; i++) access(1'b1, 2'b10, 8'(i * 4), 32'hA5, $sformatf("R5 write idx %0d", i));
    access(1'b0, 2'b10, 8'h2C, 0, "R5 read idx 11");
    access(1'b0, 2'b10, 8'h08, 0, "R5 tx unchanged");
    // R10 aliasing
    access(1'b1, 2'b10, 8'hE4, 32'h1, "R10 write wait alias");
    access(1'b0, 2'b10, 8'h64, 0, "R10 read wait alias");
    access(1'b1, 2'b10, 8'hD8, 32'h3C, "R10 timer lo alias");
    access(1'b0, 2'b10, 8'hA8, 0, "R10 read pad ctl alias");
    idle();
    idle();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule